// File: doc/BRIEF.md
# SPI Slave Hold-Condition Controller

This block sits between the pins of an SPI memory slave and its serial shift engine. It runs on a fast system clock. It brings the serial clock, the active-low chip select and the active-low pause request into that clock domain, and from these it decides when a transfer is frozen and when it continues. While frozen, it suppresses the per-edge enables that drive the shift engine, so the engine's bit position is kept. It also withdraws the serial-output enable.

A pause can start or end only during the low phase of the serial clock. A request that arrives while the clock is high waits for the next falling edge. The edge on which a pause starts or ends is itself suppressed, so an edge reaches the engine only when the controller is running both before and after that edge. If chip select is released while the transfer is frozen, the controller issues a one-cycle reset to the slave's internal logic. It then stays frozen until the pause request has been withdrawn.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While reset is asserted, and after its release with chip select high, `sck_rise_en`, `sck_fall_en`, `slave_rst` and `so_oe` are all 0.
- R2: A falling edge of `hold_n_i` while `cs_n_i` is high does not pause anything. If `cs_n_i` later goes low with `hold_n_i` still low, transfers run normally.
- R3: If the synchronized pause request falls while the synchronized SCK is low (and chip select is low), the pause takes effect in that same cycle.
- R4: If the pause request falls while SCK is high, the controller stays active until SCK next falls. The pause takes effect on that falling edge, and that edge is suppressed.
- R5: If the pause request rises while SCK is low, the controller resumes at once. If it rises while SCK is high, resumption waits for the next SCK fall, and that edge is suppressed.
- R6: While paused, `sck_rise_en`, `sck_fall_en` and `so_oe` stay 0, whatever SCK and SI do.
- R7: The pause persists for as long as the synchronized pause request stays low.
- R8: A rising edge of chip select while paused gives exactly one `slave_rst` cycle. The controller remains paused until the pause request is high, even if chip select returns low first.
- R9: The number of `sck_rise_en` pulses is unchanged across a pause interval that contains SCK toggles.
- R10: Each input passes through `SYNC_STAGES` flip-flops. Each SCK rising or falling edge gives exactly one cycle of `sck_rise_en` or `sck_fall_en` while active.
- R11: `so_oe` is 1 exactly when the controller is active and the synchronized chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the pin |
| cs_n_i | input | 1 | Active-low chip select from the pin |
| hold_n_i | input | 1 | Active-low pause request from the pin |
| sck_rise_en | output | 1 | One-cycle enable per passed SCK rising edge |
| sck_fall_en | output | 1 | One-cycle enable per passed SCK falling edge |
| so_oe | output | 1 | Serial output driver enable |
| slave_rst | output | 1 | One-cycle reset pulse for the slave logic |

## Verification
The bench builds the controller with `SYNC_STAGES` set to 3 instead of the default 2. This places every pause entry and exit three cycles behind the pin, which exposes any stage the generate loop drops or adds. SCK runs with an 8-cycle period, so both deferred paths (request changes while SCK is high) and immediate paths (request changes while SCK is low) can be placed precisely within the clock phase. Chip select is released both inside and outside a pause, so the reset pulse and the rule that a request is ignored while the slave is deselected are both exercised.

// File: rtl/hold_pkg.sv
package hold_pkg;
   typedef enum logic [1:0] {
      HC_RUN       = 2'd0,
      HC_EXIT_WAIT = 2'd1,
      HC_PAUSED    = 2'd2
   } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stage_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_LVL;
            else        stage_q[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_LVL;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hold_edge_det.sv
module hold_edge_det #(
   parameter bit RST_LVL     = 1'b0,
   parameter bit DETECT_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_LVL;
      else        prev_q <= lvl_i;
   end

   if (DETECT_RISE) begin : g_rise
      assign pulse_o = lvl_i & ~prev_q;
   end else begin : g_fall
      assign pulse_o = ~lvl_i & prev_q;
   end
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
   import hold_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sck_lvl,
   input  logic        cs_n_lvl,
   input  logic        hold_n_lvl,
   input  logic        sck_rise,
   input  logic        sck_fall,
   input  logic        hold_fall,
   input  logic        cs_rise,
   output hold_state_e state_o,
   output logic        rise_en_o,
   output logic        fall_en_o,
   output logic        so_oe_o,
   output logic        slave_rst_o
);
   hold_state_e state_q, state_d;
   logic        pend_q, pend_d;
   logic        req, enter_now, running;

   // a pause request is live only while selected and still asserted
   assign req = (pend_q | hold_fall) & ~hold_n_lvl & ~cs_n_lvl;

   always_comb begin
      state_d   = state_q;
      pend_d    = pend_q;
      enter_now = 1'b0;
      unique case (state_q)
         HC_RUN: begin
            if (req && !sck_lvl) begin
               state_d   = HC_PAUSED;
               enter_now = 1'b1;
               pend_d    = 1'b0;
            end else begin
               pend_d = req;
            end
         end
         HC_PAUSED: begin
            pend_d = 1'b0;
            if (hold_n_lvl) state_d = sck_lvl ? HC_EXIT_WAIT : HC_RUN;
         end
         HC_EXIT_WAIT: begin
            if (!hold_n_lvl)   state_d = HC_PAUSED;
            else if (!sck_lvl) state_d = HC_RUN;
         end
         default: state_d = HC_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HC_RUN;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   assign running     = (state_q == HC_RUN) & ~enter_now;
   assign rise_en_o   = sck_rise & running;
   assign fall_en_o   = sck_fall & running;
   assign so_oe_o     = running & ~cs_n_lvl;
   assign slave_rst_o = cs_rise & (state_q != HC_RUN);
   assign state_o     = state_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import hold_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic hold_n_i,
   output logic sck_rise_en,
   output logic sck_fall_en,
   output logic so_oe,
   output logic slave_rst
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_hold_ctrl: SYNC_STAGES must be at least 2");
   end

   logic        s_sck, s_cs_n, s_hold_n;
   logic        sck_rise, sck_fall, hold_fall, cs_rise;
   hold_state_e state_q;

   hold_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(s_sck));
   hold_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(s_cs_n));
   hold_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync_hold (
      .clk(clk), .rst_n(rst_n), .d_i(hold_n_i), .q_o(s_hold_n));

   hold_edge_det #(.RST_LVL(1'b0), .DETECT_RISE(1'b1)) u_sck_rise (
      .clk(clk), .rst_n(rst_n), .lvl_i(s_sck), .pulse_o(sck_rise));
   hold_edge_det #(.RST_LVL(1'b0), .DETECT_RISE(1'b0)) u_sck_fall (
      .clk(clk), .rst_n(rst_n), .lvl_i(s_sck), .pulse_o(sck_fall));
   hold_edge_det #(.RST_LVL(1'b1), .DETECT_RISE(1'b0)) u_hold_fall (
      .clk(clk), .rst_n(rst_n), .lvl_i(s_hold_n), .pulse_o(hold_fall));
   hold_edge_det #(.RST_LVL(1'b1), .DETECT_RISE(1'b1)) u_cs_rise (
      .clk(clk), .rst_n(rst_n), .lvl_i(s_cs_n), .pulse_o(cs_rise));

   hold_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .sck_lvl(s_sck), .cs_n_lvl(s_cs_n), .hold_n_lvl(s_hold_n),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .hold_fall(hold_fall), .cs_rise(cs_rise),
      .state_o(state_q),
      .rise_en_o(sck_rise_en), .fall_en_o(sck_fall_en),
      .so_oe_o(so_oe), .slave_rst_o(slave_rst));
endmodule

// File: rtl/spi_hold_ctrl_checker.sv
module spi_hold_ctrl_checker
   import hold_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input hold_state_e state_q,
   input logic        s_sck,
   input logic        s_cs_n,
   input logic        s_hold_n,
   input logic        sck_rise_en,
   input logic        sck_fall_en,
   input logic        so_oe,
   input logic        slave_rst
);
   assert_paused_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != HC_RUN) |-> (!sck_rise_en && !sck_fall_en && !so_oe));

   assert_enter_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == HC_PAUSED && $past(state_q) == HC_RUN) |-> !$past(s_sck));

   assert_resume_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == HC_RUN && $past(state_q) != HC_RUN) |-> !$past(s_sck));

   assert_pause_persist_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == HC_PAUSED && !s_hold_n) |=> (state_q == HC_PAUSED));

   assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slave_rst |=> !slave_rst);

   assert_rst_when_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slave_rst |-> (s_cs_n && state_q != HC_RUN));

   assert_oe_needs_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> !s_cs_n);
endmodule

bind spi_hold_ctrl spi_hold_ctrl_checker u_checker (
   .clk(clk), .rst_n(rst_n), .state_q(state_q),
   .s_sck(s_sck), .s_cs_n(s_cs_n), .s_hold_n(s_hold_n),
   .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
   .so_oe(so_oe), .slave_rst(slave_rst));

// File: tb/tb_spi_hold_ctrl.sv
`timescale 1ns/1ps
module tb_spi_hold_ctrl;
   localparam int SYNC = 3;
   localparam int HALF = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
   logic rise_en, fall_en, oe, srst;
   int   n_cmp = 0, n_bad = 0;
   int   c_rise = 0, c_fall = 0, c_rst = 0, c_oe = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   spi_hold_ctrl #(.SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
      .sck_rise_en(rise_en), .sck_fall_en(fall_en), .so_oe(oe), .slave_rst(srst));

   // behavioural reference: pin histories, a mode number and a pending flag
   bit q_sck[$], q_cs[$], q_hld[$];
   bit p_sck, p_cs, p_hld;
   int mode;  // 0 running, 1 paused, 2 waiting for SCK low to resume
   bit pend;
   bit x_rise, x_fall, x_oe, x_rst, x_want, x_in;

   task automatic ref_init();
      q_sck = {}; q_cs = {}; q_hld = {};
      for (int i = 0; i < SYNC; i++) begin
         q_sck.push_back(1'b0); q_cs.push_back(1'b1); q_hld.push_back(1'b1);
      end
      p_sck = 0; p_cs = 1; p_hld = 1; mode = 0; pend = 0;
   endtask

   task automatic ref_eval();
      bit s, c, h;
      s = q_sck[0]; c = q_cs[0]; h = q_hld[0];
      x_want = (pend || (!h && p_hld)) && !h && !c;
      x_in   = (mode == 0) && x_want && !s;
      x_rise = s && !p_sck && mode == 0 && !x_in;
      x_fall = !s && p_sck && mode == 0 && !x_in;
      x_oe   = mode == 0 && !x_in && !c;
      x_rst  = c && !p_cs && mode != 0;
   endtask

   task automatic ref_step();
      bit s, h;
      ref_eval();
      s = q_sck[0]; h = q_hld[0];
      if (mode == 0) begin
         if (x_in) begin mode = 1; pend = 0; end else pend = x_want;
      end else if (mode == 1) begin
         pend = 0;
         if (h) mode = s ? 2 : 0;
      end else begin
         if (!h) mode = 1; else if (!s) mode = 0;
      end
      p_sck = q_sck[0]; p_cs = q_cs[0]; p_hld = q_hld[0];
      void'(q_sck.pop_front()); void'(q_cs.pop_front()); void'(q_hld.pop_front());
      q_sck.push_back(sck); q_cs.push_back(cs_n); q_hld.push_back(hold_n);
      ref_eval();
   endtask

   task automatic cmp(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      ref_step();
      cmp("R6", "sck_rise_en", rise_en, x_rise);
      cmp("R6", "sck_fall_en", fall_en, x_fall);
      cmp("R11", "so_oe", oe, x_oe);
      cmp("R8", "slave_rst", srst, x_rst);
      c_rise += int'(rise_en); c_fall += int'(fall_en);
      c_rst += int'(srst); c_oe += int'(oe);
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic sck_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         sck = 1'b1; wait_n(HALF);
         sck = 1'b0; wait_n(HALF);
      end
   endtask

   task automatic chk_int(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      #(5ns * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int r0, f0, o0;
      // R1: quiet in reset
      repeat (3) @(negedge clk);
      chk_int("R1", "outputs in reset", int'({rise_en, fall_en, oe, srst}), 0);
      rst_n = 1'b1;
      ref_init();
      wait_n(6);
      chk_int("R1", "outputs after reset", int'({rise_en, fall_en, oe, srst}), 0);

      // R11: select drives output enable
      cs_n = 1'b0; wait_n(6);
      chk_int("R11", "so_oe selected", int'(oe), 1);

      // R10: one enable per edge
      r0 = c_rise; f0 = c_fall;
      sck_cycles(4);
      chk_int("R10", "rise pulses", c_rise - r0, 4);
      chk_int("R10", "fall pulses", c_fall - f0, 4);

      // R3: request while SCK low pauses at once
      hold_n = 1'b0; wait_n(SYNC);
      chk_int("R3", "so_oe after sync latency", int'(oe), 0);

      // R6, R9: toggles during the pause are not passed
      r0 = c_rise; f0 = c_fall; o0 = c_oe;
      sck_cycles(3);
      chk_int("R9", "rises across pause", c_rise - r0, 0);
      chk_int("R6", "falls across pause", c_fall - f0, 0);
      chk_int("R6", "so_oe cycles in pause", c_oe - o0, 0);

      // R7: long pause persists
      wait_n(40);
      chk_int("R7", "so_oe long pause", int'(oe), 0);

      // R5: release while SCK high is deferred to the fall
      sck = 1'b1; wait_n(6);
      hold_n = 1'b1; wait_n(6);
      chk_int("R5", "so_oe before SCK fall", int'(oe), 0);
      f0 = c_fall;
      sck = 1'b0; wait_n(6);
      chk_int("R5", "so_oe after SCK fall", int'(oe), 1);
      chk_int("R5", "exit fall suppressed", c_fall - f0, 0);
      r0 = c_rise;
      sck_cycles(2);
      chk_int("R9", "rises after resume", c_rise - r0, 2);

      // R4: request while SCK high waits for the fall
      sck = 1'b1; wait_n(6);
      hold_n = 1'b0; wait_n(6);
      chk_int("R4", "still active while SCK high", int'(oe), 1);
      f0 = c_fall;
      sck = 1'b0; wait_n(6);
      chk_int("R4", "paused after SCK fall", int'(oe), 0);
      chk_int("R4", "entry fall suppressed", c_fall - f0, 0);

      // R8: deselect during pause resets the slave once
      r0 = c_rst;
      cs_n = 1'b1; wait_n(8);
      chk_int("R8", "slave_rst pulses", c_rst - r0, 1);
      cs_n = 1'b0; wait_n(8);
      chk_int("R8", "still paused with request low", int'(oe), 0);
      hold_n = 1'b1; wait_n(6);
      chk_int("R8", "resumes after request release", int'(oe), 1);

      // R2: request while deselected is ignored
      cs_n = 1'b1; wait_n(6);
      hold_n = 1'b0; wait_n(6);
      cs_n = 1'b0; wait_n(6);
      chk_int("R2", "so_oe with stale request", int'(oe), 1);
      r0 = c_rise;
      sck_cycles(2);
      chk_int("R2", "rises with stale request", c_rise - r0, 2);
      hold_n = 1'b1; cs_n = 1'b1; wait_n(8);
      chk_int("R11", "so_oe deselected", int'(oe), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule